// File: doc/BRIEF.md
# Receive Descriptor Ring Controller

This block is the device-side control for one receive ring of buffer descriptors kept in host memory. Software writes one configuration word and a write index through a small register port. The configuration word selects a mode, the ring size, the size of each buffer, where interrupts go and a close timeout. The write index marks how far the host has prepared buffers. The controller owns a fill index. Each time a frame starts and a free slot exists, it asks for the descriptor at that slot. Each time a frame finishes, it closes the buffer, moves the fill index on and writes the new index to the status location.

Interrupts can go out in two ways. With a zero timeout, an interrupt follows every buffer close. With a non-zero timeout, one coalesced interrupt follows a quiet interval after the most recent close. The mode field can stop the channel at once or let the frame in progress finish first, and an idle flag tells software when the channel has actually stopped. Moving data is done elsewhere. This block only produces the descriptor index to fetch, the buffer length and the status writes.

Top module: `rxring_dma`

## Requirements
- R1: After reset the configuration is zero, so the channel is off: `idle` is 1 and `fetch_req`, `stat_we` and `irq` are 0.
- R2: Configuration bits 31:30 set the mode: 2 is run, 1 is drain, 0 is off, and 3 acts as off. A frame start is accepted only in run mode, only when no buffer is open and only when a slot is free. An accepted start gives a one-cycle `fetch_req` one cycle later, with `fetch_idx` equal to the current fill index. A start that is not accepted gives no `fetch_req`.
- R3: Configuration bits 17:16 set the buffer size, and `buf_len` is 4096*(code+1) bytes (4K, 8K, 12K or 16K).
- R4: A frame done while a buffer is open in run or drain mode closes the buffer. One cycle later `stat_we` pulses once, and `stat_idx` is the advanced fill index.
- R5: The write index register takes `reg_wdata[11:0]` when `reg_sel`=1. Its low 3 bits are ignored, and it is masked to the ring size. No slot is free when the fill index equals this limit.
- R6: Configuration bits 23:20 give log2 of the ring entry count. Values below 5 are treated as 5 and values above 12 as 12. The fill index wraps to 0 after the last entry.
- R7: Configuration bits 13:12 set the interrupt target. Only the code 01 produces `irq`. With a timeout of 0, `irq` pulses in the same cycle as the matching `stat_we`.
- R8: Configuration bits 11:4 set the timeout T in units of 32 `us_tick` pulses. With T non-zero, `irq` pulses on the 32*T-th tick after the latest close. Every close restarts the count.
- R9: In drain mode, an open buffer may still be closed by frame done, and new starts are refused. `idle` rises when that buffer closes.
- R10: In off mode, an open buffer is abandoned one cycle later without a status write or a fill index change, and `idle` rises in that same cycle.
- R11: In run mode, `idle` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the configuration word, 1 selects the write index |
| reg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Pulse: a frame begins arriving |
| frame_done | input | 1 | Pulse: the current frame has been fully stored |
| us_tick | input | 1 | One pulse per microsecond |
| fetch_req | output | 1 | Pulse: fetch the descriptor at `fetch_idx` |
| fetch_idx | output | 12 | Ring slot of the descriptor to fetch |
| buf_len | output | 15 | Buffer length in bytes from the size field |
| stat_we | output | 1 | Pulse: write `stat_idx` to the status location |
| stat_idx | output | 12 | Fill index after the latest close |
| irq | output | 1 | Interrupt pulse to the host |
| idle | output | 1 | Channel stopped, with no buffer open |

## Verification
A fill index that is off by even one shows up at once. The next accepted start reports a wrong `fetch_idx`, and the next close writes a wrong `stat_idx`. The scoreboard compares every status write against a queue of expected indices, so a missing, extra or misordered close is caught on the cycle it happens. A wrong free-slot limit shows up as a start accepted on a full ring, or refused on a ring with space, one cycle after the start pulse. A timer that counts wrongly moves the `irq` pulse away from the exact tick where the bench expects it, or leaves it out entirely. A wrong buffer-open flag shows up in `idle` within one cycle of a mode change.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  parameter int IDX_W     = 12;  // widest ring index
  parameter int LOG_MIN   = 5;   // smallest ring: 32 entries
  parameter int LOG_MAX   = 12;  // largest ring: 4096 entries
  parameter int TMO_W     = 8;   // timeout field width
  parameter int TMO_SHIFT = 5;   // timeout unit: 32 ticks
  parameter int CNT_W     = TMO_W + TMO_SHIFT;
  parameter int LEN_W     = 15;
  parameter int STEP_LSB  = 3;   // host index granularity: 8 entries

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_DRAIN = 2'd1,
    MODE_RUN   = 2'd2,
    MODE_RSVD  = 2'd3
  } rxr_mode_e;

  typedef struct packed {
    rxr_mode_e        mode;
    logic [3:0]       ring_log;
    logic [1:0]       bsize;
    logic [1:0]       dest;
    logic [TMO_W-1:0] tmo;
  } rxr_cfg_t;

  function automatic rxr_cfg_t cfg_decode(input logic [31:0] w);
    rxr_cfg_t c;
    c.mode     = rxr_mode_e'(w[31:30]);
    c.ring_log = w[23:20];
    c.bsize    = w[17:16];
    c.dest     = w[13:12];
    c.tmo      = w[11:4];
    return c;
  endfunction

  function automatic logic [IDX_W-1:0] ring_mask(input logic [3:0] lg);
    int l;
    l = int'(lg);
    if (l < LOG_MIN) l = LOG_MIN;
    if (l > LOG_MAX) l = LOG_MAX;
    return IDX_W'((1 << l) - 1);
  endfunction

  function automatic logic [IDX_W-1:0] fill_limit(input logic [IDX_W-1:0] wptr,
                                                  input logic [3:0] lg);
    logic [IDX_W-1:0] step_clr;
    step_clr = ~IDX_W'((1 << STEP_LSB) - 1);
    return wptr & ring_mask(lg) & step_clr;
  endfunction

  function automatic logic [IDX_W-1:0] next_fill(input logic [IDX_W-1:0] idx,
                                                 input logic [3:0] lg);
    return (idx + 1'b1) & ring_mask(lg);
  endfunction

  function automatic logic [LEN_W-1:0] buf_bytes(input logic [1:0] code);
    logic [2:0] k;
    k = {1'b0, code} + 3'd1;
    return {k, 12'd0};
  endfunction

  function automatic logic [CNT_W-1:0] tmo_ticks(input logic [TMO_W-1:0] t);
    return {t, {TMO_SHIFT{1'b0}}};
  endfunction

endpackage

// File: rtl/rxr_cfg_regs.sv
module rxr_cfg_regs
  import rxr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [31:0]      reg_wdata,
  output rxr_cfg_t         cfg,
  output logic [IDX_W-1:0] host_wptr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg       <= '0;
      host_wptr <= '0;
    end else if (reg_we) begin
      if (reg_sel) host_wptr <= reg_wdata[IDX_W-1:0];
      else         cfg       <= cfg_decode(reg_wdata);
    end
  end

  // R1: configuration stays cleared until the first configuration write
  a_r1_cfg_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && !reg_sel) |=> (cfg == $past(cfg)));

endmodule

// File: rtl/rxr_fill_track.sv
module rxr_fill_track
  import rxr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  rxr_cfg_t         cfg,
  input  logic [IDX_W-1:0] host_wptr,
  input  logic             frame_start,
  input  logic             frame_done,
  output logic             buf_open,
  output logic             close_evt,
  output logic             fetch_req,
  output logic [IDX_W-1:0] fetch_idx,
  output logic             stat_we,
  output logic [IDX_W-1:0] stat_idx
);

  logic [IDX_W-1:0] fill_idx;
  logic             slot_free;
  logic             accept;
  logic             abort;
  logic             mode_run;
  logic             mode_off;

  assign mode_run  = (cfg.mode == MODE_RUN);
  assign mode_off  = (cfg.mode == MODE_OFF) || (cfg.mode == MODE_RSVD);
  assign slot_free = (fill_idx != fill_limit(host_wptr, cfg.ring_log));
  assign accept    = frame_start && !buf_open && mode_run && slot_free;
  assign close_evt = frame_done && buf_open && !mode_off;
  assign abort     = buf_open && mode_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_idx  <= '0;
      buf_open  <= 1'b0;
      fetch_req <= 1'b0;
      fetch_idx <= '0;
      stat_we   <= 1'b0;
      stat_idx  <= '0;
    end else begin
      fetch_req <= accept;
      stat_we   <= close_evt;
      if (accept) begin
        buf_open  <= 1'b1;
        fetch_idx <= fill_idx;
      end else if (close_evt) begin
        buf_open  <= 1'b0;
        fill_idx  <= next_fill(fill_idx, cfg.ring_log);
        stat_idx  <= next_fill(fill_idx, cfg.ring_log);
      end else if (abort) begin
        buf_open  <= 1'b0;
      end
    end
  end

  // R5: a start on a full ring is never turned into a fetch
  a_r5_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !slot_free) |=> !fetch_req);

  // R4: every close produces one status write with a moved fill index
  a_r4_close_reports: assert property (@(posedge clk) disable iff (!rst_n)
    close_evt |=> (stat_we && fill_idx != $past(fill_idx)));

  // R10: off mode drops an open buffer in the next cycle
  a_r10_off_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_open && mode_off) |=> !buf_open);

  // R2: a fetch request only follows a start seen in run mode
  a_r2_fetch_cause: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> $past(frame_start && mode_run));

endmodule

// File: rtl/rxr_irq_timer.sv
module rxr_irq_timer
  import rxr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             close_evt,
  input  logic             us_tick,
  input  logic [TMO_W-1:0] tmo,
  input  logic [1:0]       dest,
  output logic             irq
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             pending;
  logic             tmo_zero;
  logic             host_en;
  logic             expire;
  logic             fire;

  assign limit    = tmo_ticks(tmo);
  assign tmo_zero = (tmo == '0);
  assign host_en  = (dest == 2'b01);
  assign expire   = pending && !close_evt && us_tick && !tmo_zero &&
                    (cnt >= limit - CNT_W'(1));
  assign fire     = (close_evt && tmo_zero) || expire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      pending <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= fire && host_en;
      if (close_evt) begin
        pending <= !tmo_zero;
        cnt     <= '0;
      end else if (pending && us_tick) begin
        if (tmo_zero || expire) begin
          pending <= 1'b0;
          cnt     <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R7: interrupts reach the host only with the host target selected
  a_r7_host_only: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(dest) == 2'b01));

  // R8: an interrupt always has a close or an armed timer behind it
  a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(close_evt || pending));

endmodule

// File: rtl/rxring_dma.sv
module rxring_dma
  import rxr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [31:0]      reg_wdata,
  input  logic             frame_start,
  input  logic             frame_done,
  input  logic             us_tick,
  output logic             fetch_req,
  output logic [IDX_W-1:0] fetch_idx,
  output logic [LEN_W-1:0] buf_len,
  output logic             stat_we,
  output logic [IDX_W-1:0] stat_idx,
  output logic             irq,
  output logic             idle
);

  rxr_cfg_t         cfg;
  logic [IDX_W-1:0] host_wptr;
  logic             buf_open;
  logic             close_evt;

  rxr_cfg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .cfg       (cfg),
    .host_wptr (host_wptr)
  );

  rxr_fill_track u_fill (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg         (cfg),
    .host_wptr   (host_wptr),
    .frame_start (frame_start),
    .frame_done  (frame_done),
    .buf_open    (buf_open),
    .close_evt   (close_evt),
    .fetch_req   (fetch_req),
    .fetch_idx   (fetch_idx),
    .stat_we     (stat_we),
    .stat_idx    (stat_idx)
  );

  rxr_irq_timer u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .close_evt (close_evt),
    .us_tick   (us_tick),
    .tmo       (cfg.tmo),
    .dest      (cfg.dest),
    .irq       (irq)
  );

  assign buf_len = buf_bytes(cfg.bsize);
  assign idle    = !buf_open && (cfg.mode != MODE_RUN);

  // R9: idle never shows while a buffer is still open
  a_r9_idle_closed: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !buf_open);

  // R11: run mode is never reported idle
  a_r11_run_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == MODE_RUN) |-> !idle);

endmodule

// File: tb/rxring_dma_test.sv
module rxring_dma_test;

  localparam int HALF = 10;      // 50 MHz clock
  localparam int MASK = 31;      // 32-entry ring used throughout

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        frame_start = 1'b0;
  logic        frame_done = 1'b0;
  logic        us_tick = 1'b0;
  logic        fetch_req;
  logic [11:0] fetch_idx;
  logic [14:0] buf_len;
  logic        stat_we;
  logic [11:0] stat_idx;
  logic        irq;
  logic        idle;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;
  int exp_q[$];

  always #HALF clk = ~clk;

  rxring_dma uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .frame_start(frame_start), .frame_done(frame_done),
    .us_tick(us_tick), .fetch_req(fetch_req), .fetch_idx(fetch_idx),
    .buf_len(buf_len), .stat_we(stat_we), .stat_idx(stat_idx),
    .irq(irq), .idle(idle)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(input int m, input int lg, input int sz,
                                         input int ds, input int tm);
    return (32'(m) << 30) | (32'(lg) << 20) | (32'(sz) << 16) |
           (32'(ds) << 12) | (32'(tm) << 4);
  endfunction

  task automatic wr(input logic sel, input logic [31:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic start_pulse(input bit exp_acc, input int exp_idx, input string req);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    check(fetch_req == exp_acc, {req, " fetch_req"}, int'(fetch_req), int'(exp_acc));
    if (exp_acc)
      check(fetch_idx == 12'(exp_idx), {req, " fetch_idx"}, int'(fetch_idx), exp_idx);
  endtask

  task automatic done_pulse(input bit exp_irq, input string req);
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
    check(irq == exp_irq, {req, " irq"}, int'(irq), int'(exp_irq));
  endtask

  // one accepted frame, scoreboard fed with the expected status index
  task automatic frame(input int idx, input bit exp_irq, input string req);
    start_pulse(1'b1, idx, req);
    exp_q.push_back((idx + 1) & MASK);
    done_pulse(exp_irq, req);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      us_tick = 1'b1;
      @(negedge clk);
    end
    us_tick = 1'b0;
  endtask

  // monitor: every status write must match the head of the queue (R4)
  always @(negedge clk) begin
    if (rst_n && stat_we) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4/R10 unexpected status write", int'(stat_idx), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(stat_idx == 12'(e), "R4 stat_idx", int'(stat_idx), e);
      end
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(2 * HALF * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(idle == 1'b1, "R1 idle", int'(idle), 1);
    check(fetch_req == 1'b0 && stat_we == 1'b0 && irq == 1'b0, "R1 outputs quiet", 1, 0);

    // run, 32 entries, 8K buffers, host irq, no timeout
    wr(1'b0, mk_cfg(2, 5, 1, 1, 0));
    check(idle == 1'b0, "R11 idle in run", int'(idle), 0);
    check(buf_len == 15'd8192, "R3 buf_len 8K", int'(buf_len), 8192);

    // R5: write index 0 equals fill index: full
    start_pulse(1'b0, 0, "R5 full at start");

    // R5: 13 rounds down to 8
    wr(1'b1, 32'd13);
    for (int i = 0; i < 8; i++) frame(i, 1'b1, "R7 irq per close R2");
    start_pulse(1'b0, 0, "R5 low bits ignored");

    // R6: fill up to 24, then index 32 masks to 0, wrap 31 -> 0
    wr(1'b1, 32'd24);
    for (int i = 8; i < 24; i++) frame(i, 1'b1, "R2 sequential");
    wr(1'b1, 32'd32);
    for (int i = 24; i < 32; i++) frame(i, 1'b1, "R6 wrap");
    start_pulse(1'b0, 0, "R6 full after wrap");

    // R7: target 00 gives no interrupt; R3 4K
    wr(1'b1, 32'd8);
    wr(1'b0, mk_cfg(2, 5, 0, 0, 0));
    check(buf_len == 15'd4096, "R3 buf_len 4K", int'(buf_len), 4096);
    frame(0, 1'b0, "R7 no host target");

    // R8: timeout 1 unit = 32 ticks, restarted by a close
    wr(1'b0, mk_cfg(2, 5, 0, 1, 1));
    frame(1, 1'b0, "R8 close no irq");
    ticks(31);
    check(irq == 1'b0, "R8 before expiry", int'(irq), 0);
    frame(2, 1'b0, "R8 restart");
    ticks(31);
    check(irq == 1'b0, "R8 restarted count", int'(irq), 0);
    ticks(1);
    check(irq == 1'b1, "R8 expiry", int'(irq), 1);
    @(negedge clk);
    check(irq == 1'b0, "R8 single pulse", int'(irq), 0);

    // R9: drain mode lets the open buffer finish
    wr(1'b0, mk_cfg(2, 5, 3, 1, 0));
    check(buf_len == 15'd16384, "R3 buf_len 16K", int'(buf_len), 16384);
    start_pulse(1'b1, 3, "R9 open");
    wr(1'b0, mk_cfg(1, 5, 3, 1, 0));
    check(idle == 1'b0, "R9 busy while open", int'(idle), 0);
    start_pulse(1'b0, 0, "R9 new start refused");
    exp_q.push_back(4);
    done_pulse(1'b1, "R9 close in drain");
    check(idle == 1'b1, "R9 idle after close", int'(idle), 1);
    start_pulse(1'b0, 0, "R9 refused after idle");

    // R10: off mode abandons the open buffer
    wr(1'b0, mk_cfg(2, 5, 3, 1, 0));
    start_pulse(1'b1, 4, "R10 open");
    wr(1'b0, 32'd0);
    check(idle == 1'b0, "R10 not yet idle", int'(idle), 0);
    @(negedge clk);
    check(idle == 1'b1, "R10 idle next cycle", int'(idle), 1);
    done_pulse(1'b0, "R10 done ignored");
    @(negedge clk);
    wr(1'b0, mk_cfg(2, 5, 3, 1, 0));
    frame(4, 1'b1, "R10 fill unchanged");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R4 all status writes seen", exp_q.size(), 0);
    finish_run();
  end

endmodule